// File: doc/BRIEF.md
# Page-Mode Nibble DRAM Sequencer

This block moves one byte per memory slot between a requester and a DRAM array that is four bits wide. It runs from a 16 MHz clock. A slot lasts eight clock phases, so one slot is 500 ns. In each slot the block opens a row with a single row strobe. It then issues two page-mode column strobes, and each of them moves one nibble.

The requester pulses a start strobe together with a 15-bit byte address, write data and a read/write flag. The block then runs the whole slot on its own. It multiplexes row and column addresses onto one 8-bit bus and drives the active-low strobes. On a write it drives the data nibbles. On a read it collects the two nibbles and reports the byte with a one-cycle valid pulse. Refresh and arbitration are left to the surrounding logic.

Top module: `nibble_dram_seq`

## Requirements
- R1: After reset and while no slot is running, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `dram_addr` is 0 and `rd_valid` is low.
- R2: A slot begins in the cycle after `slot_start` is sampled high and lasts 8 cycles, numbered phase 0 to 7. `dram_ras_n` is low in phases 1 to 6 only, so it falls exactly once per slot.
- R3: `dram_cas_n` is low in phase 3 and in phases 5 and 6, which gives two falling edges per slot. It is never low while `dram_ras_n` is high.
- R4: `dram_addr` carries the row `addr[14:7]` in phases 0 and 1. It carries `{addr[6:0],0}` in phases 2 and 3, and `{addr[6:0],1}` in phases 4 to 7. The address is therefore already stable in the cycle before each strobe falls.
- R5: `dram_we_n` is low in all 8 phases of a write slot and high throughout a read slot.
- R6: In a write slot, `dram_dq` carries `wdata[3:0]` in phases 2 and 3 and `wdata[7:4]` in phases 4 to 7. The block drives `dram_dq` at no other time.
- R7: In a read slot, the nibble on `dram_dq` is sampled at the end of phase 4 (low nibble) and at the end of phase 6 (high nibble). `rd_data` = {high, low} and `rd_valid` is high for exactly one cycle, in phase 7.
- R8: A `slot_start` that arrives during phases 0 to 6 of a running slot is ignored, including its address, data and flag. A `slot_start` in phase 7 starts the next slot back to back.
- R9: `rd_data` keeps its value until the next read slot completes. Write slots do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz phase clock |
| rst_n | input | 1 | synchronous active-low reset |
| slot_start | input | 1 | begins a byte slot |
| req_addr | input | 15 | byte address |
| req_wdata | input | 8 | byte to write |
| req_write | input | 1 | 1 = write, 0 = read |
| dram_addr | output | 8 | multiplexed row/column address |
| dram_ras_n | output | 1 | row strobe, active low |
| dram_cas_n | output | 1 | column strobe, active low |
| dram_we_n | output | 1 | write enable, active low |
| dram_dq | inout | 4 | nibble data path |
| rd_data | output | 8 | assembled read byte |
| rd_valid | output | 1 | one-cycle pulse when `rd_data` is new |

## Verification
The assertions check on every cycle that:
- a column strobe only appears inside an open row,
- the address is steady when a column strobe falls,
- the row strobe stays low for six phases,
- the write enable does not change inside a row cycle,
- data is driven only during writes,
- the valid signal is a single-cycle pulse.

The following can only be shown by the bench's scenarios, which use a behavioural DRAM that latches row and column on the strobe edges:
- that nibbles land at the right array locations and come back in the right order;
- that a start in mid-slot is ignored while a start in phase 7 chains slots;
- that the read byte survives intervening writes.

// File: rtl/nibble_dram_seq.sv
`timescale 1ns/10ps
module nibble_dram_seq #(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_start,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_write,
  output logic [DW-1:0] dram_addr,
  output logic          dram_ras_n,
  output logic          dram_cas_n,
  output logic          dram_we_n,
  inout  wire  [NW-1:0] dram_dq,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int CW = AW - DW;

  logic          busy;
  logic [2:0]    ph;
  logic [AW-1:0] a_q;
  logic [DW-1:0] wd_q;
  logic          wr_q;
  logic [NW-1:0] lo_q;
  logic          nib;
  logic          dq_oe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ph       <= '0;
      a_q      <= '0;
      wd_q     <= '0;
      wr_q     <= 1'b0;
      lo_q     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (slot_start && (!busy || ph == 3'd7)) begin
        busy <= 1'b1;
        ph   <= '0;
        a_q  <= req_addr;
        wd_q <= req_wdata;
        wr_q <= req_write;
      end else if (busy) begin
        ph <= ph + 3'd1;
        if (ph == 3'd7) busy <= 1'b0;
      end
      if (busy && !wr_q && ph == 3'd4) lo_q <= dram_dq;
      if (busy && !wr_q && ph == 3'd6) begin
        rd_data  <= {dram_dq, lo_q};
        rd_valid <= 1'b1;
      end
    end
  end

  assign nib        = ph >= 3'd4;
  assign dram_ras_n = !(busy && ph >= 3'd1 && ph <= 3'd6);
  assign dram_cas_n = !(busy && (ph == 3'd3 || ph == 3'd5 || ph == 3'd6));
  assign dram_we_n  = !(busy && wr_q);
  assign dram_addr  = !busy      ? '0 :
                      ph < 3'd2  ? a_q[AW-1:CW] :
                                   {a_q[CW-1:0], nib};
  assign dq_oe      = busy && wr_q && ph >= 3'd2;
  assign dram_dq    = dq_oe ? (nib ? wd_q[DW-1:NW] : wd_q[NW-1:0]) : 'z;
endmodule

module nibble_dram_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic [DW-1:0] addr,
  input logic          rd_valid,
  input logic          dq_oe
);
  AST_RAS_LOW_SIX: assert property (@(posedge clk) disable iff (!rst_n) $rose(ras_n) |-> !$past(ras_n, 6)); // R2
  AST_CAS_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n) !cas_n |-> !ras_n); // R3
  AST_ADDR_STEADY_AT_CAS: assert property (@(posedge clk) disable iff (!rst_n) $fell(cas_n) |-> $stable(addr)); // R4
  AST_WE_STEADY_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n) (!ras_n && $past(!ras_n)) |-> $stable(we_n)); // R5
  AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> !we_n); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R7
endmodule

bind nibble_dram_seq nibble_dram_seq_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .addr(dram_addr), .rd_valid(rd_valid), .dq_oe(dq_oe)
);

// File: tb/nibble_dram_seq_tb_top.sv
`timescale 1ns/10ps
module nibble_dram_seq_tb_top;
  localparam real CLK_PERIOD = 62.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_start = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_write = 1'b0;
  logic [7:0]  dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n;
  wire  [3:0]  dram_dq;
  logic [7:0]  rd_data;
  logic        rd_valid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2.0) clk = ~clk;

  nibble_dram_seq dut_i (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq(dram_dq), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // behavioural DRAM: latches row/column on strobe falls, nibble array keyed by {row,col}
  function automatic logic [3:0] fill(int k);
    return 4'((k * 5 + 3) & 15);
  endfunction

  logic [3:0] mem [int];
  logic       prev_ras = 1'b1, prev_cas = 1'b1;
  logic [7:0] row_lat = '0;
  logic       mdrv = 1'b0;
  logic [3:0] mval = '0;
  assign dram_dq = mdrv ? mval : 'z;

  always @(posedge clk) begin
    int key;
    prev_ras <= dram_ras_n;
    prev_cas <= dram_cas_n;
    if (dram_ras_n) mdrv <= 1'b0;
    if (!dram_ras_n && prev_ras) row_lat <= dram_addr;
    if (!dram_cas_n && prev_cas) begin
      key = {16'd0, row_lat, dram_addr};
      if (!dram_we_n) mem[key] = dram_dq;
      else begin
        mval <= mem.exists(key) ? mem[key] : fill(key);
        mdrv <= 1'b1;
      end
    end
  end

  // reference sequencer model
  int         rph = 0;
  bit         rbusy = 0;
  logic [14:0] ra = '0;
  logic [7:0] rw = '0;
  bit         rwr = 0;
  logic [7:0] shadow [int];
  logic [7:0] exp_rd = '0;
  logic [7:0] last_rd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rbusy = 0; rph = 0; last_rd = '0;
    end else begin
      if (rbusy && rph == 7 && !rwr) last_rd = exp_rd;
      if (slot_start && (!rbusy || rph == 7)) begin
        rbusy = 1; rph = 0; ra = req_addr; rw = req_wdata; rwr = req_write;
        if (rwr) shadow[int'(ra)] = rw;
        else exp_rd = shadow.exists(int'(ra)) ? shadow[int'(ra)]
                      : {fill(int'(ra) * 2 + 1), fill(int'(ra) * 2)};
      end else if (rbusy) begin
        if (rph == 7) rbusy = 0; else rph++;
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic e_ras, e_cas, e_we, e_v;
    logic [7:0] e_addr;
    if (rst_n && !done) begin
      e_ras  = !(rbusy && rph >= 1 && rph <= 6);
      e_cas  = !(rbusy && (rph == 3 || rph == 5 || rph == 6));
      e_we   = !(rbusy && rwr);
      e_addr = !rbusy ? 8'd0 : (rph < 2 ? ra[14:7] : {ra[6:0], 1'(rph >= 4)});
      e_v    = rbusy && rph == 7 && !rwr;
      check(dram_ras_n === e_ras, "R2 ras_n", int'(dram_ras_n), int'(e_ras));
      check(dram_cas_n === e_cas, "R3 cas_n", int'(dram_cas_n), int'(e_cas));
      check(dram_addr === e_addr, "R4 addr", int'(dram_addr), int'(e_addr));
      check(dram_we_n === e_we, "R5 we_n", int'(dram_we_n), int'(e_we));
      if (rbusy && rwr && rph >= 2)
        check(dram_dq === (rph >= 4 ? rw[7:4] : rw[3:0]), "R6 dq",
              int'(dram_dq), int'(rph >= 4 ? rw[7:4] : rw[3:0]));
      check(rd_valid === e_v, "R7 rd_valid", int'(rd_valid), int'(e_v));
      if (e_v) check(rd_data === exp_rd, "R7 rd_data", int'(rd_data), int'(exp_rd));
      else check(rd_data === last_rd, "R9 rd_data hold", int'(rd_data), int'(last_rd));
    end
  end

  // drives at a negedge, returns at the negedge inside phase 7
  task automatic slot(logic [14:0] a, logic [7:0] d, logic w);
    slot_start = 1'b1; req_addr = a; req_wdata = d; req_write = w;
    @(negedge clk);
    slot_start = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset / idle state
    check(dram_ras_n === 1'b1 && dram_cas_n === 1'b1 && dram_we_n === 1'b1,
          "R1 strobes idle", int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
    check(dram_addr === 8'd0, "R1 addr idle", int'(dram_addr), 0);
    check(rd_valid === 1'b0, "R1 rd_valid idle", int'(rd_valid), 0);
    @(negedge clk);
    // unwritten reads (R7 ordering against the fill pattern)
    slot(15'h0000, 8'h00, 1'b0); @(negedge clk);
    slot(15'h7FFF, 8'h00, 1'b0); @(negedge clk);
    // writes at extremes and middle (R5, R6)
    slot(15'h0000, 8'hA5, 1'b1); @(negedge clk);
    slot(15'h7FFF, 8'h3C, 1'b1); @(negedge clk);
    slot(15'h2A55, 8'hF0, 1'b1); @(negedge clk);
    // read back (R4 mapping, R7)
    slot(15'h0000, 8'h00, 1'b0); @(negedge clk);
    slot(15'h7FFF, 8'h00, 1'b0); @(negedge clk);
    slot(15'h2A55, 8'h00, 1'b0); @(negedge clk);
    // R9: a write after a read leaves rd_data untouched
    slot(15'h1234, 8'h99, 1'b1); @(negedge clk);
    // R8: back-to-back chaining in phase 7
    slot(15'h1234, 8'h00, 1'b0);
    slot(15'h0080, 8'h5A, 1'b1);
    slot(15'h0080, 8'h00, 1'b0);
    slot(15'h0081, 8'h00, 1'b0); @(negedge clk);
    // R8: start in mid-slot is ignored
    slot_start = 1'b1; req_addr = 15'h0100; req_wdata = 8'h00; req_write = 1'b0;
    @(negedge clk);
    slot_start = 1'b0;
    repeat (3) @(negedge clk);
    slot_start = 1'b1; req_addr = 15'h0200; req_wdata = 8'hEE; req_write = 1'b1;
    @(negedge clk);
    slot_start = 1'b0;
    repeat (3) @(negedge clk);
    check(dram_addr === {7'h00, 1'b1}, "R8 ignored start addr", int'(dram_addr), 1);
    repeat (4) @(negedge clk);
    check(dram_ras_n === 1'b1, "R8 no second slot", int'(dram_ras_n), 1);
    slot(15'h0200, 8'h00, 1'b0); @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule